// File: doc/BRIEF.md
# Four-Wire Display Command Engine with Readback

This block is a serial-bus master for a display controller that takes a separate data/command select line next to chip select, clock and the two data lines. The host hands it one command at a time over a valid/ready handshake: an opcode, a direction flag and a byte count. On a write, the engine shifts the opcode out with the select line low. It then raises the select line and pulls the parameter bytes from the host one by one through a take strobe. On a read, the engine shifts the opcode out and clocks in the response with the select line held low. Each returned byte comes back on a data port with a valid strobe, and a done strobe closes the command.

Two read opcodes, display identification and display status, come back with one dummy bit in front of the data. For these the engine clocks one more byte than requested and realigns the stream on the fly, so the host sees clean bytes. The serial clock rate is set again at the start of every byte transfer from the direction and the length of the transfer. A built-in power-mode check issues the power-mode read itself and reports whether the display is fully on, ignoring the reserved bits.

Top module: `dbi_cmd_engine`

## Requirements
- R1: A write shifts the opcode with `spi_dc` low, then drives `spi_dc` high and shifts `cmd_len` parameter bytes in the order the host supplies them. `par_take` pulses once per byte, and `par_data` is sampled in that cycle. Data is sent MSB first, changes while `spi_sclk` is low and is stable at each rising edge.
- R2: A write with `cmd_len` = 0 shifts only the opcode byte and never raises `spi_dc`.
- R3: A read shifts the opcode, then clocks in `cmd_len` response bytes with `spi_dc` low for the whole transaction. `spi_miso` is sampled on rising edges, MSB first. Each byte is returned on `rd_data` with a one-cycle `rd_valid`.
- R4: A read of opcode 0x04 (identification) or 0x09 (status) clocks `cmd_len`+1 bytes after the opcode.
- R5: For those two opcodes, returned byte i is the raw byte i shifted left by one, with bit 7 of raw byte i+1 in bit 0.
- R6: A read of 0x04 or 0x09 with a length other than 3 or 4 is refused: `err` and `done` pulse together and the bus stays idle.
- R7: A read with `cmd_len` = 0 is refused the same way.
- R8: The read opcodes are 0x04, 0x06–0x0F, 0x2E, 0x3E, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1 and 0xA8. A request whose `cmd_rd` flag disagrees with the opcode's membership in this list is refused the same way.
- R9: Every byte of a read, opcode included, runs at the lower of `READ_CAP_HZ` and half of `LINK_HZ`.
- R10: On writes, the opcode byte, and the parameters when there are `SHORT_MAX` (64) or fewer, run at the lower of `SHORT_CAP_HZ` and `LINK_HZ`. When there are more parameters, they run at `LINK_HZ`.
- R11: With `cmd_chk` set, the engine reads one byte of opcode 0x0A. `disp_on` is then 1 exactly when (byte AND 0x7C) equals 0x1C, and is updated in the cycle of `done`.
- R12: After reset and between commands, `spi_cs_n` is 1, `spi_sclk` is 0 and `cmd_ready` is 1. `cmd_ready` is 0 while a command runs. Each accepted command gives exactly one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, request taken this cycle |
| cmd_op | input | 8 | Opcode |
| cmd_rd | input | 1 | 1 = read request, 0 = write |
| cmd_len | input | LEN_W | Parameter or response byte count |
| cmd_chk | input | 1 | Run the power-mode check instead (overrides op, dir, len) |
| par_data | input | 8 | Current parameter byte |
| par_take | output | 1 | Parameter byte consumed this cycle |
| rd_data | output | 8 | Returned response byte |
| rd_valid | output | 1 | `rd_data` valid strobe |
| done | output | 1 | Command finished (one cycle) |
| err | output | 1 | Command refused (with `done`) |
| disp_on | output | 1 | Result of the last power-mode check |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_dc | output | 1 | Data/command select, 0 = command |

## Verification
A sequencer in the wrong state shows up on the bus at once. The select line changes in the middle of a byte, the chip select rises with bytes still owed, or the clock rate is wrong for the transfer type. All of these appear within one serial bit time. A realignment fault shows on `rd_data` at the first returned byte of an identification or status read, because every bit shifts by one. A wrong remaining-byte count is seen at the ports in two ways: the number of clock edges the slave sees within the same chip-select window differs, and `done` arrives early or late. A bad power-mode decode flips `disp_on` in the `done` cycle of the check.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

  localparam logic [7:0] OP_IDENT  = 8'h04;
  localparam logic [7:0] OP_STATUS = 8'h09;
  localparam logic [7:0] OP_POWER  = 8'h0A;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPC,
    ST_PARM,
    ST_RESP
  } eng_state_t;

  function automatic logic is_read_op(input logic [7:0] op);
    case (op)
      8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C,
      8'h0D, 8'h0E, 8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54,
      8'h56, 8'h5F, 8'hA1, 8'hA8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic has_dummy_bit(input logic [7:0] op);
    return (op == OP_IDENT) || (op == OP_STATUS);
  endfunction

  // clock cycles per half serial period, rounded up so the rate never exceeds the cap
  function automatic int unsigned half_cycles(input int unsigned clk_hz,
                                              input int unsigned rate_hz);
    int unsigned h;
    h = (clk_hz + 2 * rate_hz - 1) / (2 * rate_hz);
    return (h == 0) ? 1 : h;
  endfunction

  function automatic logic [7:0] realign(input logic [7:0] earlier,
                                         input logic [7:0] later);
    return {earlier[6:0], later[7]};
  endfunction

  function automatic logic power_full_on(input logic [7:0] pm);
    return (pm & 8'h7C) == 8'h1C;
  endfunction

endpackage

// File: rtl/dbi_rate_div.sv
module dbi_rate_div #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          tick
);
  logic [HW-1:0] cnt;

  assign tick = run && (cnt == half - HW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + HW'(1);
  end
endmodule

// File: rtl/dbi_byte_shift.sv
module dbi_byte_shift #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    tx,
  input  logic [HW-1:0] half,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rx,
  output logic          sclk,
  output logic          mosi
);
  logic       tick;
  logic [2:0] bit_i;
  logic [7:0] sh;

  dbi_rate_div #(.HW(HW)) div_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(half), .tick(tick)
  );

  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      bit_i <= '0;
      sh    <= '0;
      rx    <= '0;
      sclk  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          sh    <= tx;
          bit_i <= '0;
          sclk  <= 1'b0;
        end
      end else if (tick) begin
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_i == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bit_i <= bit_i + 3'd1;
            sh    <= {sh[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/dbi_cmd_engine.sv
module dbi_cmd_engine
  import dbi_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 200_000_000,
  parameter int unsigned LINK_HZ      = 20_000_000,
  parameter int unsigned READ_CAP_HZ  = 2_000_000,
  parameter int unsigned SHORT_CAP_HZ = 10_000_000,
  parameter int unsigned SHORT_MAX    = 64,
  parameter int          LEN_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_op,
  input  logic             cmd_rd,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_chk,
  input  logic [7:0]       par_data,
  output logic             par_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             err,
  output logic             disp_on,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_dc
);
  localparam int          HW = 16;
  localparam int          CW = LEN_W + 1;
  localparam int unsigned RD_RATE    = (READ_CAP_HZ < LINK_HZ / 2) ? READ_CAP_HZ : LINK_HZ / 2;
  localparam int unsigned SHORT_RATE = (SHORT_CAP_HZ < LINK_HZ) ? SHORT_CAP_HZ : LINK_HZ;
  localparam logic [HW-1:0] RD_HALF    = HW'(half_cycles(CLK_HZ, RD_RATE));
  localparam logic [HW-1:0] SHORT_HALF = HW'(half_cycles(CLK_HZ, SHORT_RATE));
  localparam logic [HW-1:0] LONG_HALF  = HW'(half_cycles(CLK_HZ, LINK_HZ));

  eng_state_t       st;
  logic             rd_q, chk_q, pad_q, first_q;
  logic [LEN_W-1:0] len_q;
  logic [CW-1:0]    left;
  logic [7:0]       prev_q;
  logic [HW-1:0]    half_q, next_half;
  logic             cs_n_q, dc_q, done_q, err_q, rd_valid_q, disp_on_q;
  logic [7:0]       rd_data_q;

  // request decode
  logic             eff_rd;
  logic [7:0]       eff_op;
  logic [LEN_W-1:0] eff_len;
  logic             req_bad;

  // named internal events
  logic       sh_start, sh_busy, sh_done;
  logic [7:0] sh_tx, sh_rx, emit;
  logic       last_byte, rd_phase;

  assign eff_rd  = cmd_chk | cmd_rd;
  assign eff_op  = cmd_chk ? OP_POWER : cmd_op;
  assign eff_len = cmd_chk ? LEN_W'(1) : cmd_len;

  always_comb begin
    req_bad = 1'b0;
    if (eff_rd != is_read_op(eff_op)) req_bad = 1'b1;
    if (eff_rd && (eff_len == '0)) req_bad = 1'b1;
    if (eff_rd && has_dummy_bit(eff_op) &&
        !((eff_len == LEN_W'(3)) || (eff_len == LEN_W'(4)))) req_bad = 1'b1;
  end

  assign last_byte = (left == CW'(1));
  assign rd_phase  = (st == ST_RESP) || ((st == ST_OPC) && rd_q);
  assign emit      = pad_q ? realign(prev_q, sh_rx) : sh_rx;

  always_comb begin
    sh_start  = 1'b0;
    sh_tx     = par_data;
    par_take  = 1'b0;
    next_half = half_q;
    case (st)
      ST_IDLE: if (cmd_valid && !req_bad) begin
        sh_start  = 1'b1;
        sh_tx     = eff_op;
        next_half = eff_rd ? RD_HALF : SHORT_HALF;
      end
      ST_OPC: if (sh_done) begin
        if (rd_q) begin
          sh_start = 1'b1;
          sh_tx    = 8'h00;
        end else if (len_q != '0) begin
          sh_start  = 1'b1;
          par_take  = 1'b1;
          next_half = ({1'b0, len_q} <= CW'(SHORT_MAX)) ? SHORT_HALF : LONG_HALF;
        end
      end
      ST_PARM: if (sh_done && !last_byte) begin
        sh_start = 1'b1;
        par_take = 1'b1;
      end
      ST_RESP: if (sh_done && !last_byte) begin
        sh_start = 1'b1;
        sh_tx    = 8'h00;
      end
      default: ;
    endcase
  end

  dbi_byte_shift #(.HW(HW)) shift_i (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .half(half_q),
    .miso(spi_miso), .busy(sh_busy), .done(sh_done), .rx(sh_rx),
    .sclk(spi_sclk), .mosi(spi_mosi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      rd_q       <= 1'b0;
      chk_q      <= 1'b0;
      pad_q      <= 1'b0;
      first_q    <= 1'b0;
      len_q      <= '0;
      left       <= '0;
      prev_q     <= '0;
      half_q     <= SHORT_HALF;
      cs_n_q     <= 1'b1;
      dc_q       <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      disp_on_q  <= 1'b0;
    end else begin
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      if (sh_start) half_q <= next_half;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          if (req_bad) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
          end else begin
            st      <= ST_OPC;
            cs_n_q  <= 1'b0;
            dc_q    <= 1'b0;
            rd_q    <= eff_rd;
            chk_q   <= cmd_chk;
            pad_q   <= eff_rd && has_dummy_bit(eff_op);
            first_q <= 1'b1;
            len_q   <= eff_len;
          end
        end
        ST_OPC: if (sh_done) begin
          if (rd_q) begin
            st   <= ST_RESP;
            left <= {1'b0, len_q} + CW'(pad_q);
          end else if (len_q == '0) begin
            st     <= ST_IDLE;
            cs_n_q <= 1'b1;
            done_q <= 1'b1;
          end else begin
            st   <= ST_PARM;
            dc_q <= 1'b1;
            left <= {1'b0, len_q};
          end
        end
        ST_PARM: if (sh_done) begin
          if (last_byte) begin
            st     <= ST_IDLE;
            cs_n_q <= 1'b1;
            dc_q   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            left <= left - CW'(1);
          end
        end
        ST_RESP: if (sh_done) begin
          first_q <= 1'b0;
          prev_q  <= sh_rx;
          if (!(pad_q && first_q)) begin
            rd_data_q  <= emit;
            rd_valid_q <= 1'b1;
          end
          if (last_byte) begin
            st     <= ST_IDLE;
            cs_n_q <= 1'b1;
            done_q <= 1'b1;
            if (chk_q) disp_on_q <= power_full_on(emit);
          end else begin
            left <= left - CW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == ST_IDLE);
  assign rd_data   = rd_data_q;
  assign rd_valid  = rd_valid_q;
  assign done      = done_q;
  assign err       = err_q;
  assign disp_on   = disp_on_q;
  assign spi_cs_n  = cs_n_q;
  assign spi_dc    = dc_q;
endmodule

// File: rtl/dbi_cmd_engine_chk.sv
module dbi_cmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic done,
  input logic err,
  input logic rd_valid,
  input logic par_take,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_dc,
  input logic rd_phase,
  input logic sh_busy
);
  p_take_raises_dc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    par_take |=> spi_dc);

  p_dc_steady_in_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_busy && $past(sh_busy)) |-> $stable(spi_dc));

  p_dc_low_in_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |-> !spi_dc);

  p_data_from_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_phase));

  p_refusal_idle_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (spi_cs_n && done));

  p_ready_means_deselected_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> spi_cs_n);

  p_clock_parked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_done_closes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> done);
endmodule

bind dbi_cmd_engine dbi_cmd_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .done(done), .err(err),
  .rd_valid(rd_valid), .par_take(par_take), .spi_cs_n(spi_cs_n),
  .spi_sclk(spi_sclk), .spi_dc(spi_dc), .rd_phase(rd_phase), .sh_busy(sh_busy)
);

// File: tb/dbi_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module dbi_cmd_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_op = 8'h00;
  logic       cmd_rd = 1'b0;
  logic [7:0] cmd_len = 8'h00;
  logic       cmd_chk = 1'b0;
  logic [7:0] par_data;
  logic       par_take;
  logic [7:0] rd_data;
  logic       rd_valid, done, err, disp_on;
  logic       spi_cs_n, spi_sclk, spi_mosi, spi_dc;
  logic       spi_miso = 1'b1;

  always #2.5 clk = ~clk;

  dbi_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_rd(cmd_rd), .cmd_len(cmd_len), .cmd_chk(cmd_chk),
    .par_data(par_data), .par_take(par_take), .rd_data(rd_data),
    .rd_valid(rd_valid), .done(done), .err(err), .disp_on(disp_on),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_dc(spi_dc)
  );

  int nchk = 0;
  int nfail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // host parameter source
  logic [7:0] params [0:127];
  int pidx = 0;
  assign par_data = params[pidx];
  always @(posedge clk) if (par_take) pidx <= pidx + 1;

  // host result capture
  logic [7:0] got [0:15];
  int ngot = 0, ndone = 0, nerr = 0;
  always @(negedge clk) begin
    if (rd_valid) begin got[ngot] = rd_data; ngot++; end
    if (done) ndone++;
    if (err) nerr++;
  end

  // behavioural slave
  logic [7:0] resp [0:7];
  bit         sl_pad = 0;
  logic [7:0] sl_sh = 8'h00;
  logic [7:0] sl_bytes [0:127];
  logic       sl_dc [0:127];
  int         sl_bits = 0, dc_hits = 0;
  realtime    t_last = 0, per_first = 0, per_last = 0;

  function automatic logic resp_bit(input int k);
    int j;
    if (sl_pad) begin
      if (k == 0) return 1'b0;
      j = k - 1;
    end else j = k;
    if (j / 8 > 7) return 1'b1;
    return resp[j / 8][7 - (j % 8)];
  endfunction

  always @(posedge spi_sclk) begin
    sl_sh = {sl_sh[6:0], spi_mosi};
    if (spi_dc) dc_hits++;
    if (sl_bits % 8 == 7) begin
      sl_bytes[sl_bits / 8] = sl_sh;
      sl_dc[sl_bits / 8] = spi_dc;
    end
    if (sl_bits == 1) per_first = $realtime - t_last;
    if (sl_bits > 0) per_last = $realtime - t_last;
    t_last = $realtime;
    sl_bits++;
  end

  always @(negedge spi_sclk) if (sl_bits >= 8) spi_miso = resp_bit(sl_bits - 8);

  function automatic bit near(input realtime a, input realtime b);
    return (a - b < 0.5) && (b - a < 0.5);
  endfunction

  task automatic issue(input logic [7:0] op, input bit rd, input int len, input bit chk);
    int d0;
    sl_bits = 0; dc_hits = 0; ngot = 0; nerr = 0;
    @(negedge clk);
    pidx = 0;
    d0 = ndone;
    cmd_op = op; cmd_rd = rd; cmd_len = 8'(len); cmd_chk = chk; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (ndone == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(ndone - d0 == 1, "R12 one done per command", ndone - d0, 1);
  endtask

  task automatic t_reset;
    check(spi_cs_n === 1'b1, "R12 reset cs_n", int'(spi_cs_n), 1);
    check(spi_sclk === 1'b0, "R12 reset sclk", int'(spi_sclk), 0);
    check(cmd_ready === 1'b1, "R12 reset ready", int'(cmd_ready), 1);
    check(spi_dc === 1'b0, "R12 reset dc", int'(spi_dc), 0);
  endtask

  task automatic t_write_short;
    int d0;
    params[0] = 8'h00; params[1] = 8'h10; params[2] = 8'h00; params[3] = 8'hEF;
    sl_bits = 0; dc_hits = 0; pidx = 0;
    @(negedge clk);
    d0 = ndone;
    cmd_op = 8'h2A; cmd_rd = 0; cmd_len = 8'd4; cmd_chk = 0; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    repeat (20) @(negedge clk);
    check(cmd_ready == 1'b0, "R12 ready low while busy", int'(cmd_ready), 0);
    check(spi_cs_n == 1'b0, "R12 cs active while busy", int'(spi_cs_n), 0);
    while (ndone == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(sl_bits == 40, "R1 write bit count", sl_bits, 40);
    check(sl_bytes[0] == 8'h2A && sl_dc[0] == 0, "R1 opcode with dc low", int'(sl_bytes[0]), 'h2A);
    for (int i = 0; i < 4; i++) begin
      check(sl_bytes[i+1] == params[i], "R1 parameter value", int'(sl_bytes[i+1]), int'(params[i]));
      check(sl_dc[i+1] == 1'b1, "R1 parameter dc high", int'(sl_dc[i+1]), 1);
    end
    check(pidx == 4, "R1 take count", pidx, 4);
    check(near(per_first, 100.0), "R10 opcode rate", int'(per_first), 100);
    check(near(per_last, 100.0), "R10 short parameter rate", int'(per_last), 100);
    check(spi_cs_n == 1'b1, "R12 cs released", int'(spi_cs_n), 1);
  endtask

  task automatic t_write_zero;
    issue(8'h29, 0, 0, 0);
    check(sl_bits == 8, "R2 command only", sl_bits, 8);
    check(dc_hits == 0, "R2 dc never high", dc_hits, 0);
    check(sl_bytes[0] == 8'h29, "R2 opcode value", int'(sl_bytes[0]), 'h29);
    check(nerr == 0, "R2 no error", nerr, 0);
  endtask

  task automatic t_write_len(input int n, input realtime exp_per);
    for (int i = 0; i < n; i++) params[i] = 8'((i * 37 + 5) & 255);
    issue(8'h2C, 0, n, 0);
    check(sl_bits == (n + 1) * 8, "R10 long write bit count", sl_bits, (n + 1) * 8);
    check(sl_bytes[n] == params[n-1], "R1 last parameter", int'(sl_bytes[n]), int'(params[n-1]));
    check(sl_bytes[1] == params[0], "R1 first parameter", int'(sl_bytes[1]), int'(params[0]));
    check(near(per_first, 100.0), "R10 opcode rate on bulk write", int'(per_first), 100);
    check(near(per_last, exp_per), "R10 parameter rate by length", int'(per_last), int'(exp_per));
  endtask

  task automatic t_read_plain;
    resp[0] = 8'hA5; resp[1] = 8'h3C; sl_pad = 0;
    issue(8'h0B, 1, 2, 0);
    check(sl_bits == 24, "R3 read bit count", sl_bits, 24);
    check(dc_hits == 0, "R3 dc low in read", dc_hits, 0);
    check(ngot == 2, "R3 byte count", ngot, 2);
    check(got[0] == 8'hA5, "R3 byte 0", int'(got[0]), 'hA5);
    check(got[1] == 8'h3C, "R3 byte 1", int'(got[1]), 'h3C);
    check(near(per_first, 500.0), "R9 read opcode rate", int'(per_first), 500);
    check(near(per_last, 500.0), "R9 read data rate", int'(per_last), 500);
  endtask

  task automatic t_read_pad(input logic [7:0] op, input int n);
    resp[0] = 8'h81; resp[1] = 8'h34; resp[2] = 8'hC7; resp[3] = 8'h01; resp[4] = 8'hFF;
    sl_pad = 1;
    issue(op, 1, n, 0);
    sl_pad = 0;
    check(sl_bits == 8 * (n + 2), "R4 extra byte clocked", sl_bits, 8 * (n + 2));
    check(ngot == n, "R5 returned count", ngot, n);
    for (int i = 0; i < n; i++)
      check(got[i] == resp[i], "R5 realigned byte", int'(got[i]), int'(resp[i]));
    check(nerr == 0, "R4 no error", nerr, 0);
  endtask

  task automatic t_refused(input logic [7:0] op, input bit rd, input int n, input string req);
    issue(op, rd, n, 0);
    check(nerr == 1, req, nerr, 1);
    check(sl_bits == 0, req, sl_bits, 0);
  endtask

  task automatic t_power(input logic [7:0] pm, input bit exp_on);
    resp[0] = pm; sl_pad = 0;
    issue(8'h77, 0, 9, 1);
    check(sl_bytes[0] == 8'h0A, "R11 check opcode", int'(sl_bytes[0]), 'h0A);
    check(sl_bits == 16, "R11 one byte read", sl_bits, 16);
    check(disp_on == exp_on, "R11 power decode", int'(disp_on), int'(exp_on));
  endtask

  bit finished = 0;

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_short();
    t_write_zero();
    t_write_len(64, 100.0);
    t_write_len(65, 50.0);
    t_read_plain();
    t_read_pad(8'h04, 3);
    t_read_pad(8'h09, 4);
    t_refused(8'h04, 1, 2, "R6 ident length 2 refused");
    t_refused(8'h09, 1, 5, "R6 status length 5 refused");
    t_refused(8'h0B, 1, 0, "R7 zero read refused");
    t_refused(8'h2C, 1, 2, "R8 write opcode read refused");
    t_refused(8'h0A, 0, 1, "R8 read opcode write refused");
    t_power(8'h9F, 1);
    t_power(8'h3C, 0);
    t_power(8'h1C, 1);
    t_power(8'h14, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule